// File: doc/BRIEF.md
# SPI Flash Controller Interrupt Status Block

This block gathers the FIFO-related events of an SPI flash controller into one interrupt line. Six sources are watched: receive overflow, transmit fill below its watermark, transmit full, receive not empty, receive fill at or above its watermark, and transmit underflow. The FIFOs are outside this block. They appear only as fill levels and as push or pop strobes. A source that fires latches a bit in a status register. Software clears the bit by writing a one to it.

The interrupt mask has no write port of its own. One write address sets mask bits and a second write address clears them. The current mask is shown on a read-only output. Status and mask use the same bit layout, so software can apply one bit constant to status, set, clear and mask. Two watermark registers set the thresholds: one for the transmit level compare and one for the receive level compare. The interrupt output is high whenever a latched status bit is also enabled in the mask.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Status and mask are 7 bits wide, with this layout: bit 0 receive overflow, bit 2 transmit level below watermark, bit 3 transmit full, bit 4 receive not empty, bit 5 receive level at or above watermark, bit 6 transmit underflow. Bit 1 always reads 0 in both registers, and writing it has no effect.
- R2: A write to address 0 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R3: Every status bit stays set until it is cleared, even after its cause has gone away. When a source is active in the same cycle as a clear of its bit, the bit stays set.
- R4: A receive push (`rx_push_i`) while `rx_level_i` equals DEPTH sets bit 0. A transmit pop (`tx_pop_i`) while `tx_level_i` is 0 sets bit 6.
- R5: Bit 2 sets when `tx_level_i` is below the transmit watermark. Bit 3 sets when `tx_level_i` equals DEPTH. Bit 4 sets when `rx_level_i` is nonzero. Bit 5 sets when `rx_level_i` is at or above the receive watermark. Each status bit shows the value after the clock edge on which its condition is present.
- R6: A write to address 1 sets the mask bits whose data bit is 1. A write to address 2 clears the mask bits whose data bit is 1. `mask_o` shows the current mask.
- R7: A write to address 3 loads the transmit watermark from the low LVL_W bits of the data. A write to address 4 loads the receive watermark in the same way. A watermark takes effect on the cycle after it is written.
- R8: `irq_o` is high exactly when some bit of status AND mask is 1. It follows the registers in the same cycle.
- R9: Reset clears status and mask, sets the transmit watermark to 1 and sets the receive watermark to 32.
- R10: A write to address 5, 6 or 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_push_i | input | 1 | Receive FIFO push strobe |
| tx_pop_i | input | 1 | Transmit FIFO pop strobe |
| wr_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write target: 0 clear status, 1 set mask, 2 clear mask, 3 transmit watermark, 4 receive watermark |
| wr_data_i | input | WR_W | Write data |
| status_o | output | 7 | Latched event status |
| mask_o | output | 7 | Current interrupt enables |
| tx_wm_o | output | LVL_W | Transmit watermark |
| rx_wm_o | output | LVL_W | Receive watermark |
| irq_o | output | 1 | Interrupt request |

## Verification
Random fill levels are weighted toward 0 and DEPTH, so the full, empty, overflow and underflow comparisons all fire often, along with the ordinary in-between values. Random writes go to all eight addresses. This checks that set and clear reach only the intended register, and that addresses 5 to 7 do nothing. Directed steps cover cases that random stimulus rarely produces. One is a clear landing in the same cycle as an active level condition, which tells set-wins priority apart from clear-wins priority. Another is a sticky overflow that must survive after its cause goes away. The last is a watermark change, which shows whether bit 2 compares against the programmed value or against a fixed one.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NSRC = 7;
  localparam int B_RX_OVF  = 0;
  localparam int B_TX_LOW  = 2;
  localparam int B_TX_FULL = 3;
  localparam int B_RX_NE   = 4;
  localparam int B_RX_WM   = 5;
  localparam int B_TX_UNF  = 6;
  localparam logic [NSRC-1:0] SRC_VALID = 7'b111_1101;

  typedef enum logic [2:0] {
    A_STS_CLR = 3'd0,
    A_EN_SET  = 3'd1,
    A_DIS_CLR = 3'd2,
    A_TX_WM   = 3'd3,
    A_RX_WM   = 3'd4
  } wr_addr_e;
endpackage

// File: rtl/irq_evt_gen.sv
module irq_evt_gen
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 63,
  parameter int LVL_W = 6
) (
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             rx_push_i,
  input  logic             tx_pop_i,
  input  logic [LVL_W-1:0] tx_wm_i,
  input  logic [LVL_W-1:0] rx_wm_i,
  output logic [NSRC-1:0]  evt_o
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic rx_full, tx_empty;
  assign rx_full  = (rx_level_i == FULL_LVL);
  assign tx_empty = (tx_level_i == '0);

  always_comb begin
    evt_o            = '0;
    evt_o[B_RX_OVF]  = rx_push_i & rx_full;
    evt_o[B_TX_LOW]  = (tx_level_i < tx_wm_i);
    evt_o[B_TX_FULL] = (tx_level_i == FULL_LVL);
    evt_o[B_RX_NE]   = ~(rx_level_i == '0);
    evt_o[B_RX_WM]   = (rx_level_i >= rx_wm_i);
    evt_o[B_TX_UNF]  = tx_pop_i & tx_empty;
  end
endmodule

// File: rtl/irq_bit_reg.sv
// Per-bit set/clear register; SET_WINS picks priority when both arrive together.
module irq_bit_reg #(
  parameter int N        = 7,
  parameter bit SET_WINS = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else if (SET_WINS) begin
        if (set_i[i])      q <= 1'b1;
        else if (clr_i[i]) q <= 1'b0;
      end else begin
        if (clr_i[i])      q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;
      end
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/irq_wm_reg.sv
module irq_wm_reg #(
  parameter int W   = 6,
  parameter int RST = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= W'(RST);
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int DEPTH     = 63,
  parameter int TX_WM_RST = 1,
  parameter int RX_WM_RST = 32,
  localparam int LVL_W    = $clog2(DEPTH + 1),
  localparam int WR_W     = (LVL_W > NSRC) ? LVL_W : NSRC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             rx_push_i,
  input  logic             tx_pop_i,
  input  logic             wr_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [WR_W-1:0]  wr_data_i,
  output logic [NSRC-1:0]  status_o,
  output logic [NSRC-1:0]  mask_o,
  output logic [LVL_W-1:0] tx_wm_o,
  output logic [LVL_W-1:0] rx_wm_o,
  output logic             irq_o
);
  logic [NSRC-1:0] evt, wr_bits, sts_clr, msk_set, msk_clr;
  logic            we_txwm, we_rxwm;

  assign wr_bits = wr_data_i[NSRC-1:0] & SRC_VALID;
  assign sts_clr = (wr_i && wr_addr_i == A_STS_CLR) ? wr_bits : '0;
  assign msk_set = (wr_i && wr_addr_i == A_EN_SET)  ? wr_bits : '0;
  assign msk_clr = (wr_i && wr_addr_i == A_DIS_CLR) ? wr_bits : '0;
  assign we_txwm = wr_i && (wr_addr_i == A_TX_WM);
  assign we_rxwm = wr_i && (wr_addr_i == A_RX_WM);

  irq_evt_gen #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_evt (
    .tx_level_i (tx_level_i),
    .rx_level_i (rx_level_i),
    .rx_push_i  (rx_push_i),
    .tx_pop_i   (tx_pop_i),
    .tx_wm_i    (tx_wm_o),
    .rx_wm_i    (rx_wm_o),
    .evt_o      (evt)
  );

  // level sources re-latch over a concurrent clear
  irq_bit_reg #(.N(NSRC), .SET_WINS(1'b1)) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt & SRC_VALID),
    .clr_i  (sts_clr),
    .q_o    (status_o)
  );

  irq_bit_reg #(.N(NSRC), .SET_WINS(1'b0)) u_msk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (msk_set),
    .clr_i  (msk_clr),
    .q_o    (mask_o)
  );

  irq_wm_reg #(.W(LVL_W), .RST(TX_WM_RST)) u_txwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_txwm),
    .d_i    (wr_data_i[LVL_W-1:0]),
    .q_o    (tx_wm_o)
  );

  irq_wm_reg #(.W(LVL_W), .RST(RX_WM_RST)) u_rxwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_rxwm),
    .d_i    (wr_data_i[LVL_W-1:0]),
    .q_o    (rx_wm_o)
  );

  assign irq_o = |(status_o & mask_o);
endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk #(
  parameter int DEPTH = 63,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int WR_W  = (LVL_W > 7) ? LVL_W : 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] tx_level_i,
  input logic [LVL_W-1:0] rx_level_i,
  input logic             rx_push_i,
  input logic             tx_pop_i,
  input logic             wr_i,
  input logic [2:0]       wr_addr_i,
  input logic [WR_W-1:0]  wr_data_i,
  input logic [6:0]       status_o,
  input logic [6:0]       mask_o,
  input logic [LVL_W-1:0] tx_wm_o,
  input logic [LVL_W-1:0] rx_wm_o,
  input logic             irq_o
);
  AST_BIT1_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[1] && !mask_o[1]); // R1

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !(wr_i && wr_addr_i == 3'd0 && wr_data_i[0])) |=> status_o[0]); // R3

  AST_RX_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_level_i == LVL_W'(DEPTH)) |=> status_o[0]); // R4

  AST_TX_UNF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pop_i && tx_level_i == '0) |=> status_o[6]); // R4

  AST_TX_LOW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_i < tx_wm_o) |=> status_o[2]); // R5

  AST_RX_WM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_i >= rx_wm_o) |=> status_o[5]); // R5

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_addr_i == 3'd1) |=>
      ((mask_o & $past(wr_data_i[6:0]) & 7'h7D) == ($past(wr_data_i[6:0]) & 7'h7D))); // R6

  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_addr_i == 3'd2) |=> ((mask_o & $past(wr_data_i[6:0])) == 7'h00)); // R6

  AST_WM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (wr_addr_i == 3'd3 || wr_addr_i == 3'd4)) |=>
      ($stable(tx_wm_o) && $stable(rx_wm_o))); // R7

  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o == 7'h00) |-> !irq_o); // R8

  AST_IRQ_NEEDS_STS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o != 7'h00)); // R8
endmodule

bind spi_irq_ctrl spi_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_level_i (tx_level_i),
  .rx_level_i (rx_level_i),
  .rx_push_i  (rx_push_i),
  .tx_pop_i   (tx_pop_i),
  .wr_i       (wr_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .status_o   (status_o),
  .mask_o     (mask_o),
  .tx_wm_o    (tx_wm_o),
  .rx_wm_o    (rx_wm_o),
  .irq_o      (irq_o)
);

// File: tb/sim_spi_irq_ctrl.sv
`timescale 1ns/1ps
module sim_spi_irq_ctrl;
  localparam int DEPTH = 63;
  localparam int LW    = 6;
  localparam int WW    = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] tx_l = '0, rx_l = '0;
  logic          push = 1'b0, pop = 1'b0, wr = 1'b0;
  logic [2:0]    addr = '0;
  logic [WW-1:0] data = '0;
  logic [6:0]    sts, msk;
  logic [LW-1:0] twm, rwm;
  logic          irq;

  int n_chk = 0, n_fail = 0;
  logic [6:0]    m_sts, m_msk;
  logic [LW-1:0] m_twm, m_rwm;

  always #5 clk = ~clk;

  spi_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_level_i(tx_l), .rx_level_i(rx_l),
    .rx_push_i(push), .tx_pop_i(pop), .wr_i(wr), .wr_addr_i(addr),
    .wr_data_i(data), .status_o(sts), .mask_o(msk), .tx_wm_o(twm),
    .rx_wm_o(rwm), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] evt_f();
    logic [6:0] e = '0;
    e[0] = push && (rx_l == LW'(DEPTH));
    e[2] = tx_l < m_twm;
    e[3] = tx_l == LW'(DEPTH);
    e[4] = rx_l != 0;
    e[5] = rx_l >= m_rwm;
    e[6] = pop && (tx_l == 0);
    return e;
  endfunction

  function automatic string req_of(int b);
    if (b == 1) return "R1";
    if (b == 0 || b == 6) return "R4";
    return "R5";
  endfunction

  task automatic compare_all();
    for (int b = 0; b < 7; b++)
      chk(sts[b] == m_sts[b], req_of(b), $sformatf("status[%0d]", b), sts[b], m_sts[b]);
    chk(msk == m_msk, "R6", "mask", msk, m_msk);
    chk(twm == m_twm, "R7", "tx_wm", twm, m_twm);
    chk(rwm == m_rwm, "R7", "rx_wm", rwm, m_rwm);
    chk(irq == |(m_sts & m_msk), "R8", "irq", irq, |(m_sts & m_msk));
  endtask

  // drive at negedge, advance model, compare at next negedge
  task automatic step(input logic [LW-1:0] t, input logic [LW-1:0] r,
                      input logic pu, input logic po, input logic w,
                      input logic [2:0] a, input logic [WW-1:0] d);
    logic [6:0] e, wb, n_sts, n_msk;
    logic [LW-1:0] n_twm, n_rwm;
    tx_l = t; rx_l = r; push = pu; pop = po; wr = w; addr = a; data = d;
    e  = evt_f();
    wb = d & 7'h7D;
    n_sts = m_sts; n_msk = m_msk; n_twm = m_twm; n_rwm = m_rwm;
    if (w && a == 3'd0) n_sts = n_sts & ~wb;
    n_sts = n_sts | e;
    if (w && a == 3'd1) n_msk = n_msk | wb;
    if (w && a == 3'd2) n_msk = n_msk & ~wb;
    if (w && a == 3'd3) n_twm = d[LW-1:0];
    if (w && a == 3'd4) n_rwm = d[LW-1:0];
    @(negedge clk);
    m_sts = n_sts; m_msk = n_msk; m_twm = n_twm; m_rwm = n_rwm;
    compare_all();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] s_sts, s_msk;
    void'($urandom(32'd1234));
    m_sts = '0; m_msk = '0; m_twm = LW'(1); m_rwm = LW'(32);
    tx_l = LW'(10);
    repeat (2) @(negedge clk);
    // R9 reset values
    chk(sts == 0 && msk == 0, "R9", "status|mask in reset", {sts, msk}, 0);
    chk(twm == 1 && rwm == 32, "R9", "watermarks in reset", {twm, rwm}, {LW'(1), LW'(32)});
    rst_n = 1'b1;

    step(10, 0, 0, 0, 0, 0, 0);
    chk(sts == 0, "R9", "status idle after reset", sts, 0);
    // overflow on push into full RX, then cause removed
    step(10, 63, 1, 0, 0, 0, 0);
    step(10, 0, 0, 0, 0, 0, 0);
    chk(sts[0] == 1, "R3", "overflow sticky", sts[0], 1);
    // W1C bit 0 only
    step(10, 0, 0, 0, 1, 3'd0, 7'h01);
    chk(sts[0] == 0, "R2", "clear bit0", sts[0], 0);
    chk(sts[4] == 1, "R2", "bit4 untouched", sts[4], 1);
    // clear while not-empty condition active
    step(10, 5, 0, 0, 1, 3'd0, 7'h10);
    chk(sts[4] == 1, "R3", "set wins over clear", sts[4], 1);
    // mask set / clear, bit1 ignored
    step(10, 0, 0, 0, 1, 3'd1, 7'h7F);
    chk(msk == 7'h7D, "R6", "enable all", msk, 7'h7D);
    chk(msk[1] == 0, "R1", "mask bit1", msk[1], 0);
    chk(irq == 1, "R8", "irq on enabled status", irq, 1);
    step(10, 0, 0, 0, 1, 3'd2, 7'h7F);
    chk(msk == 0 && irq == 0, "R8", "irq after disable", {msk, irq}, 0);
    // watermark change
    step(30, 0, 0, 0, 1, 3'd0, 7'h7F);
    chk(sts == 0, "R2", "clear all", sts, 0);
    step(30, 0, 0, 0, 1, 3'd3, 7'h14);
    chk(sts[2] == 0 && twm == 20, "R7", "tx wm loaded", twm, 20);
    step(10, 0, 0, 0, 0, 0, 0);
    chk(sts[2] == 1, "R7", "below new tx wm", sts[2], 1);
    // unused addresses
    s_sts = sts; s_msk = msk;
    step(30, 0, 0, 0, 1, 3'd5, 7'h7F);
    step(30, 0, 0, 0, 1, 3'd7, 7'h7F);
    chk(sts == s_sts && msk == s_msk, "R10", "addr 5/7 no effect", {sts, msk}, {s_sts, s_msk});
    chk(twm == 20 && rwm == 32, "R10", "wm unchanged", {twm, rwm}, {LW'(20), LW'(32)});
    // underflow
    step(0, 0, 0, 1, 0, 0, 0);
    chk(sts[6] == 1, "R4", "tx underflow", sts[6], 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [LW-1:0] t, r;
      int k;
      k = $urandom % 8;
      t = (k == 0) ? LW'(0) : (k == 1) ? LW'(DEPTH) : LW'($urandom % 64);
      k = $urandom % 8;
      r = (k == 0) ? LW'(0) : (k == 1) ? LW'(DEPTH) : LW'($urandom % 64);
      step(t, r, ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0,
           3'($urandom % 8), WW'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule